// File: doc/BRIEF.md
# Legacy Keyboard Port Trap Register

This block is a 16-bit control and status register that records host I/O accesses to the legacy keyboard data port (60h) and command port (64h), and raises a system-management interrupt request from them. Three access kinds each have a sticky status flag: command-port write, command-port read and data-port write. A fourth flag records the end of a gate pass-through sequence. Each flag latches when its event arrives, whatever its enable bit holds. Software clears a flag by writing one to it. A separate pass-through qualifier input lets a command-port write complete without being recorded.

The block also receives the host controller's own interrupt. Bit 12 shows that interrupt live, before any gating. A read/write gate bit decides whether the interrupt reaches the ordinary PCI interrupt output. The SMI request is a level. It is high while any flag and its paired enable are both set, and it stays high until software clears the flag or the enable. Register access is synchronous, with a write strobe, two byte enables and combinational read data.

Top module: `kbd_trap_csr`

## Requirements
- R1: After reset the register reads 16'h2000 while the controller interrupt is low, and both `smi_req` and `pci_irq` are low.
- R2: Bit 13 is read/write through byte lane 1 and resets to 1. `pci_irq` equals `ctl_irq` AND bit 13.
- R3: Bit 12 always reads the current value of `ctl_irq`. Writing either value to bit 12 has no effect.
- R4: Status bit 11 sets on `ev_wr64`, bit 10 on `ev_rd64` and bit 9 on `ev_wr60`, whatever the enable bits hold.
- R5: Status bit 15 sets on `ev_pass_end`, whatever bit 7 holds.
- R6: Writing 1 to bit 15, 11, 10 or 9 with byte lane 1 enabled clears that bit. Writing 0 leaves it unchanged.
- R7: When an event and a write-1-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R8: `ev_wr64` does not set bit 11 while `pass_qual` is high. `pass_qual` has no effect on the other events.
- R9: Enable bits 7, 4, 3, 2 and 1 are read/write through byte lane 0 and reset to 0.
- R10: Bits 14, 8, 6, 5 and 0 always read 0.
- R11: `smi_req` is high exactly when at least one of these pairs has both bits set: 15/7, 12/4, 11/3, 10/2, 9/1.
- R12: A write changes only bits in a byte whose enable is set. `csr_be[0]` covers bits 7:0 and `csr_be[1]` covers bits 15:8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_be | input | 2 | Byte enables for the write |
| csr_wdata | input | 16 | Write data |
| csr_rdata | output | 16 | Read data (combinational) |
| ev_wr64 | input | 1 | One-cycle pulse: host wrote port 64h |
| ev_rd64 | input | 1 | One-cycle pulse: host read port 64h |
| ev_wr60 | input | 1 | One-cycle pulse: host wrote port 60h |
| ev_pass_end | input | 1 | One-cycle pulse: a pass-through sequence ended |
| pass_qual | input | 1 | Marks the current port 64h write as part of a pass-through |
| ctl_irq | input | 1 | Raw interrupt from the host controller |
| pci_irq | output | 1 | Gated PCI interrupt |
| smi_req | output | 1 | System-management interrupt request level |

## Verification
The register has no hidden state, so every flag and enable is visible in `csr_rdata` one clock after the event or write that changes it. A wrong status or enable bit therefore shows up on the read data at the next sample. It also shows up on `smi_req` in the same cycle whenever the paired bit is set. A wrong event-versus-clear priority or a leaking pass-through qualifier would leave a bit at the wrong value right after the colliding cycle. A gate fault on bit 13 shows immediately on `pci_irq` while `ctl_irq` is high. The bench keeps a behavioural model of every bit and compares all outputs every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/kbd_trap_pkg.sv
package kbd_trap_pkg;
  localparam int unsigned CSR_W    = 16;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned BE_W     = CSR_W / LANE_W;
  localparam int unsigned NUM_TRAP = 4;

  // Trap slot order: 0 data write, 1 command read, 2 command write, 3 pass-through end
  localparam int unsigned STS_POS [NUM_TRAP] = '{9, 10, 11, 15};
  localparam int unsigned EN_POS  [NUM_TRAP] = '{1, 2, 3, 7};

  localparam int unsigned IRQ_STS_POS = 12;
  localparam int unsigned IRQ_EN_POS  = 4;
  localparam int unsigned PIE_POS     = 13;

  localparam int unsigned SLOT_W60  = 0;
  localparam int unsigned SLOT_R64  = 1;
  localparam int unsigned SLOT_W64  = 2;
  localparam int unsigned SLOT_PASS = 3;

  function automatic int unsigned lane_of(input int unsigned pos);
    return pos / LANE_W;
  endfunction
endpackage

// File: rtl/kbd_trap_rst_sync.sv
module kbd_trap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/kbd_trap_sticky.sv
module kbd_trap_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;

  // set takes priority over a same-cycle clear
  always_comb begin
    flag_d = set_i | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/kbd_trap_ctl_reg.sv
module kbd_trap_ctl_reg #(
  parameter int unsigned NUM_EN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EN-1:0] en_wr_i,
  input  logic [NUM_EN-1:0] en_wdat_i,
  input  logic              irq_en_wr_i,
  input  logic              irq_en_wdat_i,
  input  logic              pie_wr_i,
  input  logic              pie_wdat_i,
  output logic [NUM_EN-1:0] trap_en_o,
  output logic              irq_en_o,
  output logic              pie_o
);
  logic [NUM_EN-1:0] trap_en_q, trap_en_d;
  logic              irq_en_q, irq_en_d;
  logic              pie_q, pie_d;

  always_comb begin
    for (int i = 0; i < int'(NUM_EN); i++) begin
      trap_en_d[i] = en_wr_i[i] ? en_wdat_i[i] : trap_en_q[i];
    end
    irq_en_d = irq_en_wr_i ? irq_en_wdat_i : irq_en_q;
    pie_d    = pie_wr_i    ? pie_wdat_i    : pie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_en_q <= '0;
      irq_en_q  <= 1'b0;
      pie_q     <= 1'b1;
    end else begin
      trap_en_q <= trap_en_d;
      irq_en_q  <= irq_en_d;
      pie_q     <= pie_d;
    end
  end

  assign trap_en_o = trap_en_q;
  assign irq_en_o  = irq_en_q;
  assign pie_o     = pie_q;
endmodule

// File: rtl/kbd_trap_csr.sv
module kbd_trap_csr
  import kbd_trap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [BE_W-1:0]  csr_be,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  input  logic             ev_wr64,
  input  logic             ev_rd64,
  input  logic             ev_wr60,
  input  logic             ev_pass_end,
  input  logic             pass_qual,
  input  logic             ctl_irq,
  output logic             pci_irq,
  output logic             smi_req
);
  logic                rst_core_n;
  logic [BE_W-1:0]     lane_wr;
  logic [NUM_TRAP-1:0] trap_ev;
  logic [NUM_TRAP-1:0] trap_clr;
  logic [NUM_TRAP-1:0] trap_sts;
  logic [NUM_TRAP-1:0] en_wr;
  logic [NUM_TRAP-1:0] en_wdat;
  logic [NUM_TRAP-1:0] trap_en;
  logic                irq_en;
  logic                pie;
  logic                unused_wdata;

  kbd_trap_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign lane_wr[b] = csr_we & csr_be[b];
  end

  assign trap_ev[SLOT_W60]  = ev_wr60;
  assign trap_ev[SLOT_R64]  = ev_rd64;
  assign trap_ev[SLOT_W64]  = ev_wr64 & ~pass_qual;
  assign trap_ev[SLOT_PASS] = ev_pass_end;

  for (genvar i = 0; i < NUM_TRAP; i++) begin : g_trap
    assign trap_clr[i] = lane_wr[lane_of(STS_POS[i])] & csr_wdata[STS_POS[i]];
    assign en_wr[i]    = lane_wr[lane_of(EN_POS[i])];
    assign en_wdat[i]  = csr_wdata[EN_POS[i]];

    kbd_trap_sticky u_sts (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .set_i  (trap_ev[i]),
      .clr_i  (trap_clr[i]),
      .flag_o (trap_sts[i])
    );
  end

  kbd_trap_ctl_reg #(.NUM_EN(NUM_TRAP)) u_ctl (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .en_wr_i       (en_wr),
    .en_wdat_i     (en_wdat),
    .irq_en_wr_i   (lane_wr[lane_of(IRQ_EN_POS)]),
    .irq_en_wdat_i (csr_wdata[IRQ_EN_POS]),
    .pie_wr_i      (lane_wr[lane_of(PIE_POS)]),
    .pie_wdat_i    (csr_wdata[PIE_POS]),
    .trap_en_o     (trap_en),
    .irq_en_o      (irq_en),
    .pie_o         (pie)
  );

  // write data bits with no storage behind them
  assign unused_wdata = ^{csr_wdata[14], csr_wdata[12], csr_wdata[8],
                          csr_wdata[6], csr_wdata[5], csr_wdata[0]};

  always_comb begin
    csr_rdata = '0;
    for (int i = 0; i < int'(NUM_TRAP); i++) begin
      csr_rdata[STS_POS[i]] = trap_sts[i];
      csr_rdata[EN_POS[i]]  = trap_en[i];
    end
    csr_rdata[IRQ_STS_POS] = ctl_irq;
    csr_rdata[IRQ_EN_POS]  = irq_en;
    csr_rdata[PIE_POS]     = pie;
  end

  assign smi_req = (|(trap_sts & trap_en)) | (ctl_irq & irq_en);
  assign pci_irq = ctl_irq & pie;
endmodule

// File: rtl/kbd_trap_csr_chk.sv
module kbd_trap_csr_chk (
  input logic        clk,
  input logic        rst_q_n,
  input logic        wr_hi,
  input logic [1:0]  wd_sts,
  input logic [15:0] csr_rdata,
  input logic        ev_rd64,
  input logic        ev_wr60,
  input logic        ev_pass_end,
  input logic        pass_qual,
  input logic        ctl_irq,
  input logic        pci_irq,
  input logic        smi_req
);
  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (csr_rdata[14] | csr_rdata[8] | csr_rdata[6] | csr_rdata[5] | csr_rdata[0]) == 1'b0);

  p_irq_view_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    csr_rdata[12] == ctl_irq);

  p_pci_gate_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    pci_irq == (ctl_irq & csr_rdata[13]));

  p_smi_pairs_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    smi_req == ((csr_rdata[15] & csr_rdata[7]) | (csr_rdata[12] & csr_rdata[4]) |
                (csr_rdata[11] & csr_rdata[3]) | (csr_rdata[10] & csr_rdata[2]) |
                (csr_rdata[9] & csr_rdata[1])));

  p_w60_sets_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    ev_wr60 |=> csr_rdata[9]);

  p_pass_sets_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    ev_pass_end |=> csr_rdata[15]);

  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_hi && wd_sts[1] && !ev_rd64) |=> !csr_rdata[10]);

  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ev_wr60 && wr_hi && wd_sts[0]) |=> csr_rdata[9]);

  p_qual_block_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (pass_qual && !csr_rdata[11]) |=> !csr_rdata[11]);
endmodule

bind kbd_trap_csr kbd_trap_csr_chk u_chk (
  .clk         (clk),
  .rst_q_n     (rst_core_n),
  .wr_hi       (csr_we & csr_be[1]),
  .wd_sts      (csr_wdata[10:9]),
  .csr_rdata   (csr_rdata),
  .ev_rd64     (ev_rd64),
  .ev_wr60     (ev_wr60),
  .ev_pass_end (ev_pass_end),
  .pass_qual   (pass_qual),
  .ctl_irq     (ctl_irq),
  .pci_irq     (pci_irq),
  .smi_req     (smi_req)
);

// File: tb/test_kbd_trap_csr.sv
`timescale 1ns/1ps
module test_kbd_trap_csr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_we;
  logic [1:0]  csr_be;
  logic [15:0] csr_wdata;
  logic [15:0] csr_rdata;
  logic        ev_wr64, ev_rd64, ev_wr60, ev_pass_end, pass_qual, ctl_irq;
  logic        pci_irq, smi_req;

  int n_checks = 0;
  int n_fail   = 0;

  // behavioural model state
  bit s15, s11, s10, s9;
  bit e7, e4, e3, e2, e1;
  bit gate13;

  always #4 clk = ~clk;

  kbd_trap_csr i_kbd_trap_csr (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_be(csr_be),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .ev_wr64(ev_wr64), .ev_rd64(ev_rd64), .ev_wr60(ev_wr60),
    .ev_pass_end(ev_pass_end), .pass_qual(pass_qual), .ctl_irq(ctl_irq),
    .pci_irq(pci_irq), .smi_req(smi_req)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] model_rd();
    logic [15:0] r = '0;
    r[15] = s15; r[13] = gate13; r[12] = ctl_irq; r[11] = s11; r[10] = s10;
    r[9] = s9; r[7] = e7; r[4] = e4; r[3] = e3; r[2] = e2; r[1] = e1;
    return r;
  endfunction

  task automatic model_reset();
    s15 = 0; s11 = 0; s10 = 0; s9 = 0;
    e7 = 0; e4 = 0; e3 = 0; e2 = 0; e1 = 0; gate13 = 1;
  endtask

  task automatic model_clock();
    bit hi = csr_we && csr_be[1];
    bit lo = csr_we && csr_be[0];
    if (hi) begin
      if (csr_wdata[15]) s15 = 0;
      if (csr_wdata[11]) s11 = 0;
      if (csr_wdata[10]) s10 = 0;
      if (csr_wdata[9])  s9  = 0;
      gate13 = csr_wdata[13];
    end
    if (lo) begin
      e7 = csr_wdata[7]; e4 = csr_wdata[4]; e3 = csr_wdata[3];
      e2 = csr_wdata[2]; e1 = csr_wdata[1];
    end
    if (ev_pass_end)            s15 = 1;
    if (ev_wr64 && !pass_qual)  s11 = 1;
    if (ev_rd64)                s10 = 1;
    if (ev_wr60)                s9  = 1;
  endtask

  task automatic compare_all();
    logic [15:0] m = model_rd();
    bit msmi = (s15 & e7) | (ctl_irq & e4) | (s11 & e3) | (s10 & e2) | (s9 & e1);
    check("R4 status 11:9", {13'd0, csr_rdata[11:9]}, {13'd0, m[11:9]});
    check("R5 status 15", {15'd0, csr_rdata[15]}, {15'd0, m[15]});
    check("R3 live irq bit", {15'd0, csr_rdata[12]}, {15'd0, m[12]});
    check("R2 gate bit", {15'd0, csr_rdata[13]}, {15'd0, m[13]});
    check("R9 enables", csr_rdata & 16'h009E, m & 16'h009E);
    check("R10 reserved", csr_rdata & 16'h4161, 16'h0000);
    check("R11 smi", {15'd0, smi_req}, {15'd0, msmi});
    check("R2 pci", {15'd0, pci_irq}, {15'd0, ctl_irq & gate13});
  endtask

  task automatic idle_inputs();
    csr_we = 0; csr_be = 0; csr_wdata = 0;
    ev_wr64 = 0; ev_rd64 = 0; ev_wr60 = 0; ev_pass_end = 0; pass_qual = 0;
  endtask

  // inputs are set before calling, at a falling edge; one clock, then compare
  task automatic step();
    @(posedge clk);
    model_clock();
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    csr_we = 1; csr_be = be; csr_wdata = d;
    step();
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; ctl_irq = 0;
    idle_inputs();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) step();
    // R1 reset state
    check("R1 reset value", csr_rdata, 16'h2000);
    check("R1 smi low", {15'd0, smi_req}, 16'd0);
    check("R1 pci low", {15'd0, pci_irq}, 16'd0);

    // R2/R3 interrupt path
    ctl_irq = 1; step();
    check("R2 pci passes", {15'd0, pci_irq}, 16'd1);
    check("R3 bit12 live", csr_rdata, 16'h3000);
    wr(2'b10, 16'h1000);            // clears gate, tries to write bit 12
    check("R2 gate off", {15'd0, pci_irq}, 16'd0);
    ctl_irq = 0; step();
    check("R3 write ignored", csr_rdata, 16'h0000);
    wr(2'b10, 16'h2000);
    check("R2 gate back on", csr_rdata, 16'h2000);

    // R4/R5 events with enables clear
    ev_wr60 = 1; step();
    ev_rd64 = 1; step();
    ev_wr64 = 1; step();
    ev_pass_end = 1; step();
    check("R4 R5 all status set", csr_rdata, 16'hAE00);
    check("R11 no smi without enables", {15'd0, smi_req}, 16'd0);

    // R12 lane 0 write cannot clear lane 1 bits
    wr(2'b01, 16'hFF00);
    check("R12 lane isolation", csr_rdata, 16'hAE00);
    // R6 clear bit 9 only, writing 0 elsewhere
    wr(2'b10, 16'h2200);
    check("R6 w1c bit9", csr_rdata, 16'hAC00);
    // R7 event beats clear
    csr_we = 1; csr_be = 2'b10; csr_wdata = 16'h2200; ev_wr60 = 1; step();
    check("R7 event wins", csr_rdata, 16'hAE00);
    // R8 qualifier blocks command write only
    wr(2'b10, 16'h2C00);
    check("R6 w1c 11 10", csr_rdata, 16'hA200);
    ev_wr64 = 1; pass_qual = 1; step();
    check("R8 qualified write not logged", csr_rdata, 16'hA200);
    ev_rd64 = 1; pass_qual = 1; step();
    check("R8 read unaffected", csr_rdata, 16'hA600);

    // R9 enables, R11 smi
    wr(2'b01, 16'h00FF);
    check("R9 enables written", csr_rdata, 16'hA69E);
    check("R11 smi from pairs", {15'd0, smi_req}, 16'd1);
    wr(2'b11, 16'hAE00);            // clear statuses, zero enables
    check("R6 R9 cleared", csr_rdata, 16'h2000);
    wr(2'b01, 16'h0010);
    ctl_irq = 1; step();
    check("R11 irq pair", {15'd0, smi_req}, 16'd1);
    ctl_irq = 0;
    wr(2'b11, 16'hFFFF);
    check("R10 reserved after all-ones", csr_rdata & 16'h4161, 16'h0000);

    // random traffic against the model
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r = $urandom;
      csr_we = r[0] & r[1]; csr_be = r[3:2];
      csr_wdata = {r[31:24], r[15:8]} ^ 16'(r[23:16]);
      ev_wr64 = r[4]; ev_rd64 = r[5]; ev_wr60 = r[6]; ev_pass_end = r[7] & r[8];
      pass_qual = r[9]; ctl_irq = r[10];
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule